// File: doc/BRIEF.md
# Control Register Bank with Mode-Banked Stack Pointer

This block holds the control state of a small processor core: a 16-bit status word split into a current status byte and a saved status byte, a separate condition flag, a second-level saved status byte, two saved program counters, two general-purpose scratch words, and the stack pointer. Software reaches these through one combinational read port and one synchronous write port. Both ports are addressed by a 4-bit control-register index. The register file of the core reaches the live stack pointer through a separate side port.

Bit 7 of the current status byte selects the stack mode. The block keeps one live stack pointer and two stored shadows, one for the interrupt role and one for the user role. Each stack-pointer index reaches either the live copy or its own shadow, depending on the mode. When a status-word write flips the mode bit, the live pointer and the matching shadow trade places at that clock edge, so the general register file always sees the stack that belongs to the new mode. All pins are plain control and status signals. Neither port has a handshake or back-pressure: every write request is accepted at the next rising edge.

Index map: 0 status word, 1 condition flag, 2 interrupt stack pointer, 3 user stack pointer, 4 and 5 scratch, 6 first saved PC, 7 second-level saved status, 8 second-level saved PC, 9 to 15 undefined.

Top module: `ctl_regbank`

## Requirements
- R1: A read of index 0 returns zero in bits 31:16, the saved status byte ANDed with 0xC1 in bits 15:8, and the current status byte ANDed with 0xC0 in bits 7:0, with the condition flag ORed into bit 0.
- R2: A write to index 0 loads the saved status byte from data bits 15:8, the current status byte from bits 7:0, and the condition flag from bit 0. The stack mode becomes the new bit 7.
- R3: A write to index 0 that changes the stack mode from 1 to 0 copies the live stack pointer into the user shadow and loads the live stack pointer from the interrupt shadow, both at that edge.
- R4: A write to index 0 that changes the stack mode from 0 to 1 copies the live stack pointer into the interrupt shadow and loads the live stack pointer from the user shadow, both at that edge.
- R5: Index 2 reads and writes the live stack pointer when the mode is 0, and the interrupt shadow when the mode is 1. Index 3 reads and writes the live stack pointer when the mode is 1, and the user shadow when the mode is 0.
- R6: Indexes 6 and 8 store all 32 written bits and read back with bit 0 forced to 0.
- R7: Index 7 stores data bits 7:0 and reads them back ANDed with 0xC1, with zero above.
- R8: Index 1 writes only the condition flag, from data bit 0, and reads it in bit 0 with zero above.
- R9: Indexes 4 and 5 are independent 32-bit storage words.
- R10: Indexes 9 to 15 read as zero, and a write to them changes no register and not the live stack pointer.
- R11: After reset every register, including the stack mode and the live stack pointer, is zero.
- R12: The side port always shows the live stack pointer. A side-port write lands at the edge unless a control write to the live pointer (a swap, or a banked write that reaches the live copy) happens in the same cycle, in which case the control write wins.
- R13: Reads are combinational and show the state before the coming clock edge, including in a cycle that writes the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cr_rd_idx | input | 4 | Control-register index to read |
| cr_rd_data | output | 32 | Read data for cr_rd_idx |
| cr_we | input | 1 | Control-register write enable |
| cr_wr_idx | input | 4 | Control-register index to write |
| cr_wr_data | input | 32 | Write data |
| gp_sp_we | input | 1 | Side-port write of the live stack pointer |
| gp_sp_wdata | input | 32 | Side-port write data |
| gp_sp_rdata | output | 32 | Live stack pointer |

## Verification
Two functions can land on the live stack pointer in the same cycle: a control-register write and a side-port write from the general register file. The bench provokes this with a mode-flipping status write, a banked write to index 2 in mode 0, and a write to a scratch index, each paired with a side-port write of a different value. Afterwards it reads the side port and the shadows. The pointer must hold the control value in the first two cases and the side-port value in the third. Each displaced value must sit in the right shadow.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
  localparam int CR_STATUS   = 0;
  localparam int CR_COND     = 1;
  localparam int CR_SP_INT   = 2;
  localparam int CR_SP_USR   = 3;
  localparam int CR_SCR_BASE = 4;
  localparam int CR_SCR_NUM  = 2;
  localparam int CR_SAVE_PC  = 6;
  localparam int CR_SAVE2_ST = 7;
  localparam int CR_SAVE2_PC = 8;
  localparam logic [7:0] SAVED_ST_MASK = 8'hC1;
  localparam logic [7:0] CUR_ST_MASK   = 8'hC0;
  localparam int MODE_BIT = 7;
endpackage

// File: rtl/ctl_status_unit.sv
module ctl_status_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_status,
  input  logic          wr_cond,
  input  logic [15:0]   wdata,
  output logic          stack_mode,
  output logic [DW-1:0] status_rd,
  output logic [DW-1:0] cond_rd
);
  import ctl_regbank_pkg::*;

  logic [7:0] cur_q, saved_q;
  logic       flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      saved_q <= '0;
      flag_q  <= 1'b0;
    end else if (wr_status) begin
      cur_q   <= wdata[7:0];
      saved_q <= wdata[15:8];
      flag_q  <= wdata[0];
    end else if (wr_cond) begin
      flag_q  <= wdata[0];
    end
  end

  assign stack_mode = cur_q[MODE_BIT];
  assign status_rd  = {{(DW-16){1'b0}}, saved_q & SAVED_ST_MASK,
                       (cur_q & CUR_ST_MASK) | {7'b0, flag_q}};
  assign cond_rd    = {{(DW-1){1'b0}}, flag_q};

  a_r2_status_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> (stack_mode == $past(wdata[7])) && (cond_rd[0] == $past(wdata[0])));
  a_r8_cond_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cond && !wr_status) |=> $stable(stack_mode) && (cond_rd[0] == $past(wdata[0])));
endmodule

// File: rtl/ctl_sp_bank.sv
module ctl_sp_bank #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stack_mode,
  input  logic          wr_status,
  input  logic          new_mode,
  input  logic          wr_sp_int,
  input  logic          wr_sp_usr,
  input  logic [DW-1:0] wdata,
  input  logic          gp_we,
  input  logic [DW-1:0] gp_wdata,
  output logic [DW-1:0] sp_live,
  output logic [DW-1:0] sp_int_rd,
  output logic [DW-1:0] sp_usr_rd
);
  logic [DW-1:0] live_q, int_q, usr_q;
  logic [DW-1:0] live_d, int_d, usr_d;
  logic          swap;

  assign swap = wr_status && (new_mode != stack_mode);

  always_comb begin
    live_d = gp_we ? gp_wdata : live_q;
    int_d  = int_q;
    usr_d  = usr_q;
    if (swap) begin
      if (stack_mode) begin
        usr_d  = live_q;
        live_d = int_q;
      end else begin
        int_d  = live_q;
        live_d = usr_q;
      end
    end else if (wr_sp_int) begin
      if (stack_mode) int_d  = wdata;
      else            live_d = wdata;
    end else if (wr_sp_usr) begin
      if (stack_mode) live_d = wdata;
      else            usr_d  = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      int_q  <= '0;
      usr_q  <= '0;
    end else begin
      live_q <= live_d;
      int_q  <= int_d;
      usr_q  <= usr_d;
    end
  end

  assign sp_live   = live_q;
  assign sp_int_rd = stack_mode ? int_q : live_q;
  assign sp_usr_rd = stack_mode ? live_q : usr_q;

  a_r3_swap_to_mode0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && stack_mode && !new_mode) |=>
      (usr_q == $past(live_q)) && (live_q == $past(int_q)));
  a_r4_swap_to_mode1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && !stack_mode && new_mode) |=>
      (int_q == $past(live_q)) && (live_q == $past(usr_q)));
  a_r5_shadow_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sp_int && stack_mode && !wr_status && !gp_we) |=>
      (int_q == $past(wdata)) && $stable(live_q));
  a_r12_ctl_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_we && wr_sp_int && !stack_mode && !wr_status) |=> (live_q == $past(wdata)));
endmodule

// File: rtl/ctl_backup_regs.sv
module ctl_backup_regs #(
  parameter int DW   = 32,
  parameter int NSCR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_pc1,
  input  logic            wr_pc2,
  input  logic            wr_st2,
  input  logic [NSCR-1:0] wr_scr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   pc1_rd,
  output logic [DW-1:0]   pc2_rd,
  output logic [DW-1:0]   st2_rd,
  output logic [DW-1:0]   scr_rd [NSCR]
);
  import ctl_regbank_pkg::*;

  logic [DW-1:0] pc1_q, pc2_q;
  logic [7:0]    st2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc1_q <= '0;
      pc2_q <= '0;
      st2_q <= '0;
    end else begin
      if (wr_pc1) pc1_q <= wdata;
      if (wr_pc2) pc2_q <= wdata;
      if (wr_st2) st2_q <= wdata[7:0];
    end
  end

  assign pc1_rd = {pc1_q[DW-1:1], 1'b0};
  assign pc2_rd = {pc2_q[DW-1:1], 1'b0};
  assign st2_rd = {{(DW-8){1'b0}}, st2_q & SAVED_ST_MASK};

  for (genvar i = 0; i < NSCR; i++) begin : g_scr
    logic [DW-1:0] scr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        scr_q <= '0;
      else if (wr_scr[i]) scr_q <= wdata;
    end
    assign scr_rd[i] = scr_q;
  end

  a_r7_st2_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st2 |=> (st2_q == $past(wdata[7:0])));
  a_r6_pc_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pc1 |=> (pc1_rd[DW-1:1] == $past(wdata[DW-1:1])) && !pc1_rd[0]);
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank #(
  parameter int DW = 32,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] cr_rd_idx,
  output logic [DW-1:0] cr_rd_data,
  input  logic          cr_we,
  input  logic [IW-1:0] cr_wr_idx,
  input  logic [DW-1:0] cr_wr_data,
  input  logic          gp_sp_we,
  input  logic [DW-1:0] gp_sp_wdata,
  output logic [DW-1:0] gp_sp_rdata
);
  import ctl_regbank_pkg::*;

  localparam int NIDX = 1 << IW;

  logic [NIDX-1:0]       hit;
  logic                  stack_mode;
  logic [DW-1:0]         status_rd, cond_rd, sp_int_rd, sp_usr_rd;
  logic [DW-1:0]         pc1_rd, pc2_rd, st2_rd;
  logic [DW-1:0]         scr_rd [CR_SCR_NUM];
  logic [CR_SCR_NUM-1:0] wr_scr;

  for (genvar k = 0; k < NIDX; k++) begin : g_dec
    assign hit[k] = cr_we && (cr_wr_idx == IW'(k));
  end
  for (genvar i = 0; i < CR_SCR_NUM; i++) begin : g_scr_we
    assign wr_scr[i] = hit[CR_SCR_BASE + i];
  end

  ctl_status_unit #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_n),
    .wr_status(hit[CR_STATUS]), .wr_cond(hit[CR_COND]),
    .wdata(cr_wr_data[15:0]), .stack_mode(stack_mode),
    .status_rd(status_rd), .cond_rd(cond_rd)
  );

  ctl_sp_bank #(.DW(DW)) u_sp (
    .clk(clk), .rst_n(rst_n), .stack_mode(stack_mode),
    .wr_status(hit[CR_STATUS]), .new_mode(cr_wr_data[MODE_BIT]),
    .wr_sp_int(hit[CR_SP_INT]), .wr_sp_usr(hit[CR_SP_USR]),
    .wdata(cr_wr_data), .gp_we(gp_sp_we), .gp_wdata(gp_sp_wdata),
    .sp_live(gp_sp_rdata), .sp_int_rd(sp_int_rd), .sp_usr_rd(sp_usr_rd)
  );

  ctl_backup_regs #(.DW(DW), .NSCR(CR_SCR_NUM)) u_bkp (
    .clk(clk), .rst_n(rst_n),
    .wr_pc1(hit[CR_SAVE_PC]), .wr_pc2(hit[CR_SAVE2_PC]),
    .wr_st2(hit[CR_SAVE2_ST]), .wr_scr(wr_scr), .wdata(cr_wr_data),
    .pc1_rd(pc1_rd), .pc2_rd(pc2_rd), .st2_rd(st2_rd), .scr_rd(scr_rd)
  );

  always_comb begin
    case (cr_rd_idx)
      IW'(CR_STATUS):       cr_rd_data = status_rd;
      IW'(CR_COND):         cr_rd_data = cond_rd;
      IW'(CR_SP_INT):       cr_rd_data = sp_int_rd;
      IW'(CR_SP_USR):       cr_rd_data = sp_usr_rd;
      IW'(CR_SCR_BASE):     cr_rd_data = scr_rd[0];
      IW'(CR_SCR_BASE + 1): cr_rd_data = scr_rd[1];
      IW'(CR_SAVE_PC):      cr_rd_data = pc1_rd;
      IW'(CR_SAVE2_ST):     cr_rd_data = st2_rd;
      IW'(CR_SAVE2_PC):     cr_rd_data = pc2_rd;
      default:              cr_rd_data = '0;
    endcase
  end

  a_r10_undef_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we && (cr_wr_idx > IW'(CR_SAVE2_PC)) && !gp_sp_we) |=>
      $stable(gp_sp_rdata) && $stable(stack_mode));
  a_r12_side_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_sp_we && !cr_we) |=> (gp_sp_rdata == $past(gp_sp_wdata)));
endmodule

// File: tb/ctl_regbank_bench.sv
module ctl_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cr_rd_idx = '0, cr_wr_idx = '0;
  logic        cr_we = 1'b0, gp_sp_we = 1'b0;
  logic [31:0] cr_wr_data = '0, gp_sp_wdata = '0;
  logic [31:0] cr_rd_data, gp_sp_rdata;

  always #4 clk = ~clk;

  ctl_regbank u_ctl_regbank (
    .clk(clk), .rst_n(rst_n), .cr_rd_idx(cr_rd_idx), .cr_rd_data(cr_rd_data),
    .cr_we(cr_we), .cr_wr_idx(cr_wr_idx), .cr_wr_data(cr_wr_data),
    .gp_sp_we(gp_sp_we), .gp_sp_wdata(gp_sp_wdata), .gp_sp_rdata(gp_sp_rdata)
  );

  typedef struct {
    logic [3:0]  idx;
    logic [31:0] exp_rd;
    logic [31:0] exp_sp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [7:0]  m_cur = 0, m_sav = 0, m_st2 = 0;
  logic        m_flag = 0;
  logic [31:0] m_sp = 0, m_spi = 0, m_spu = 0, m_pc1 = 0, m_pc2 = 0, m_s4 = 0, m_s5 = 0;

  function automatic logic [31:0] mread(input logic [3:0] i);
    case (i)
      0: return {16'h0, m_sav & 8'hC1, (m_cur & 8'hC0) | {7'b0, m_flag}};
      1: return {31'b0, m_flag};
      2: return m_cur[7] ? m_spi : m_sp;
      3: return m_cur[7] ? m_sp : m_spu;
      4: return m_s4;
      5: return m_s5;
      6: return {m_pc1[31:1], 1'b0};
      7: return {24'h0, m_st2 & 8'hC1};
      8: return {m_pc2[31:1], 1'b0};
      default: return 32'h0;
    endcase
  endfunction

  // driver: one cycle of stimulus, pushes the expected read for this cycle
  task automatic op(input bit we, input logic [3:0] widx, input logic [31:0] wd,
                    input bit gwe, input logic [31:0] gd, input logic [3:0] ridx,
                    input string tag);
    item_t it;
    bit    cr_live;
    logic  sm;
    @(negedge clk);
    cr_we = we; cr_wr_idx = widx; cr_wr_data = wd;
    gp_sp_we = gwe; gp_sp_wdata = gd; cr_rd_idx = ridx;
    it.idx = ridx; it.exp_rd = mread(ridx); it.exp_sp = m_sp; it.tag = tag;
    q.push_back(it);
    sm = m_cur[7];
    cr_live = 0;
    if (we) begin
      case (widx)
        0: begin
          if (wd[7] != sm) begin
            cr_live = 1;
            if (sm) begin m_spu = m_sp; m_sp = m_spi; end
            else    begin m_spi = m_sp; m_sp = m_spu; end
          end
          m_cur = wd[7:0]; m_sav = wd[15:8]; m_flag = wd[0];
        end
        1: m_flag = wd[0];
        2: if (sm) m_spi = wd; else begin m_sp = wd; cr_live = 1; end
        3: if (sm) begin m_sp = wd; cr_live = 1; end else m_spu = wd;
        4: m_s4 = wd;
        5: m_s5 = wd;
        6: m_pc1 = wd;
        7: m_st2 = wd[7:0];
        8: m_pc2 = wd;
        default: ;
      endcase
    end
    if (gwe && !cr_live) m_sp = gd;
  endtask

  task automatic rd(input logic [3:0] ridx, input string tag);
    op(0, 4'd0, 32'h0, 0, 32'h0, ridx, tag);
  endtask

  // monitor: samples mid low phase, well before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks += 2;
        if (cr_rd_data !== it.exp_rd) begin
          errors++;
          $display("FAIL %s idx=%0d rd_data actual=%h expected=%h", it.tag, it.idx, cr_rd_data, it.exp_rd);
        end
        if (gp_sp_rdata !== it.exp_sp) begin
          errors++;
          $display("FAIL %s live_sp actual=%h expected=%h", it.tag, gp_sp_rdata, it.exp_sp);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) rd(4'(i), "R11 reset");
    // side port write, then banked reads in mode 0 (R5, R12)
    op(0, 0, 0, 1, 32'h1111_0000, 2, "R12 side write");
    rd(2, "R5 int idx live in mode0");
    op(1, 3, 32'h2222_0000, 0, 0, 3, "R5 usr shadow write");
    rd(3, "R5 usr shadow read");
    // same-cycle read of written index shows old value (R13)
    op(1, 4, 32'hA5A5_5A5A, 0, 0, 4, "R13 pre-edge read");
    rd(4, "R9 scratch0");
    op(1, 5, 32'h0F0F_F0F1, 0, 0, 4, "R9 scratch0 kept");
    rd(5, "R9 scratch1");
    // mode 0 -> 1 swap (R4), status format (R1, R2)
    op(1, 0, 32'h0000_FF81, 0, 0, 0, "R4 swap up");
    rd(0, "R1 status read");
    rd(2, "R4 int shadow holds old live");
    rd(3, "R5 usr idx live in mode1");
    op(1, 2, 32'h3333_0000, 0, 0, 2, "R5 int shadow write mode1");
    rd(2, "R5 int shadow read mode1");
    // mode 1 -> 0 swap with competing side write (R3, R12)
    op(1, 0, 32'h0000_1200, 1, 32'h9999_9999, 0, "R3 swap down with side write");
    rd(3, "R3 usr shadow holds old live");
    rd(0, "R2 status after clear");
    // banked write to live in mode0 vs side write (R12)
    op(1, 2, 32'h4444_0004, 1, 32'h7777_7777, 2, "R12 ctl wins");
    rd(2, "R12 ctl value kept");
    // non-conflicting control write with side write (R12)
    op(1, 4, 32'hCAFE_0000, 1, 32'h5555_5555, 4, "R12 side lands");
    rd(4, "R9 scratch0 updated");
    // condition flag (R8)
    op(1, 1, 32'hFFFF_FFFF, 0, 0, 1, "R8 cond write");
    rd(1, "R8 cond read");
    rd(0, "R8 cond in status");
    op(1, 1, 32'h0000_0002, 0, 0, 1, "R8 bit0 only");
    rd(1, "R8 cond cleared");
    // backup PCs (R6) and second-level status (R7)
    op(1, 6, 32'hABCD_0001, 0, 0, 6, "R6 pc1 write");
    op(1, 8, 32'hFFFF_FFFF, 0, 0, 6, "R6 pc1 read");
    rd(8, "R6 pc2 read");
    op(1, 7, 32'h1234_56FF, 0, 0, 7, "R7 st2 write");
    rd(7, "R7 st2 read");
    // undefined indexes (R10)
    op(1, 12, 32'hDEAD_BEEF, 0, 0, 12, "R10 undef write");
    rd(12, "R10 undef read");
    op(1, 9, 32'h0000_0080, 0, 0, 15, "R10 undef bit7");
    rd(0, "R10 status untouched");
    rd(2, "R10 live untouched");
    rd(4, "R10 scratch untouched");
    // flip to mode1 again then back, full round trip (R3, R4)
    op(1, 0, 32'h0000_0080, 0, 0, 3, "R4 second swap up");
    rd(3, "R4 usr live");
    op(1, 3, 32'h6666_0000, 1, 32'h8888_0000, 3, "R12 usr live ctl wins");
    rd(3, "R12 usr live value");
    op(1, 0, 32'h0000_0000, 0, 0, 2, "R3 second swap down");
    rd(2, "R3 int live");
    rd(3, "R3 usr shadow");
    rd(0, "R2 final status");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule